// File: doc/BRIEF.md
# Three-Wire Serial Control Register Decoder

This block receives write-only configuration traffic over three wires (a mode line, a serial clock and a serial data line) and turns it into a small set of parallel audio-converter settings. Traffic is byte-oriented. While the mode line is low, the block takes bytes as address bytes. While it is high, it takes them as data bytes. An address byte carries a fixed device identity in its upper six bits and a two-bit group selector in its lower two bits. Each data byte that follows then writes one sub-register of the selected group. The top two bits of the data byte choose that sub-register.

All three control wires are asynchronous to the system clock. Each one passes through a synchronizer chain, and serial clock edges are detected inside the system clock domain. The settings are the clock ratio, the serial audio format, the attenuation code, the de-emphasis choice and the mute flag. They leave the block as plain registered outputs, and other logic consumes them directly.

Top module: `ctl3w_regfile`

## Requirements
- R1: After reset the outputs are clock ratio 2'b10 (256fs), format 3'b000 (I2S), attenuation 6'd0 (0 dB), de-emphasis 2'b00 (off) and mute 0, and the device is not selected. Data bytes sent before any matching address change nothing.
- R2: An address byte is received with the mode line low. Its bits [7:2] select the device only when they equal 6'b000101. Any other value deselects the device, and later data bytes change no output.
- R3: Address bits [1:0] choose the group. 2'b00 is the playback group (attenuation, de-emphasis, mute) and 2'b10 is the configuration group (clock ratio, format). With 2'b01 or 2'b11, data bytes change no output.
- R4: Bits are taken least significant first, one on each rising serial clock edge. No output changes until the eighth bit of a byte has arrived.
- R5: In the playback group, a data byte with bits [7:6]=2'b00 loads the attenuation output from bits [5:0].
- R6: In the playback group, a data byte with bits [7:6]=2'b10 loads de-emphasis from bits [4:3] (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and mute from bit 2 (1 = muted). Bytes with bits [7:6] equal to 2'b01 or 2'b11 change nothing.
- R7: In the configuration group, a data byte with bits [7:6]=2'b00 loads the clock ratio from bits [5:4] (00 512fs, 01 384fs, 10 256fs) and the format from bits [3:1] (000 I2S, 001/010/011 right-justified 16/18/20 bit, 100 left-justified). Other values of bits [7:6] change nothing.
- R8: A clock-ratio code of 2'b11 leaves the clock ratio unchanged, and a format code above 3'b100 leaves the format unchanged. Each of the two fields is judged on its own.
- R9: The device selection and group stay in force for any number of data bytes, until the next address byte.
- R10: Every transition of the mode line discards a partly received byte. The next eight bits then form a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode_i | input | 1 | Mode line: low for address bytes, high for data bytes |
| ctl_clk_i | input | 1 | Serial clock; a bit is taken on each rising edge |
| ctl_dat_i | input | 1 | Serial data, least significant bit first |
| clk_ratio_o | output | 2 | System clock ratio code |
| fmt_o | output | 3 | Serial audio format code |
| vol_o | output | 6 | Attenuation code, 1 dB per step |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Soft mute enable |

## Verification
The bench sends every one of the 256 address bytes, each followed by a data byte. A decoder that compares too few address bits, or that treats the unused group codes as valid, writes registers it must leave alone. It sweeps every attenuation code, every de-emphasis and mute pair, and all 32 configuration pairs. The sweep includes the reserved ratio and format codes, which a design without the per-field guard would store. It also stops a byte after seven bits to catch an early commit, and toggles the mode line in the middle of a byte. A bit counter that survives that toggle frames the next byte wrongly and stores a shifted value.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
   localparam int unsigned CTL_BYTE_W = 8;

   typedef enum logic [1:0] {
      GRP_PLAY  = 2'b00,
      GRP_RSV1  = 2'b01,
      GRP_CONF  = 2'b10,
      GRP_RSV3  = 2'b11
   } grp_e;

   typedef enum logic [1:0] {
      SUB_MAIN  = 2'b00,
      SUB_RSV1  = 2'b01,
      SUB_AUX   = 2'b10,
      SUB_RSV3  = 2'b11
   } sub_e;

   localparam logic [1:0] RATIO_256   = 2'b10;
   localparam logic [1:0] RATIO_BAD   = 2'b11;
   localparam logic [2:0] FMT_I2S     = 3'b000;
   localparam logic [2:0] FMT_LAST_OK = 3'b100;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_s,
   input  logic              sclk_s,
   input  logic              sdat_s,
   output logic [BYTE_W-1:0] byte_o,
   output logic              vld_o,
   output logic              is_data_o
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic              sclk_q, mode_q;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] sh_nxt;

   assign sh_nxt = {sdat_s, sh[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         mode_q    <= 1'b0;
         cnt       <= '0;
         sh        <= '0;
         byte_o    <= '0;
         vld_o     <= 1'b0;
         is_data_o <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         mode_q <= mode_s;
         vld_o  <= 1'b0;
         if (mode_s != mode_q) begin
            cnt <= '0;
         end else if (sclk_s && !sclk_q) begin
            sh <= sh_nxt;
            if (cnt == CNT_LAST) begin
               cnt       <= '0;
               byte_o    <= sh_nxt;
               vld_o     <= 1'b1;
               is_data_o <= mode_s;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
   import ctl3w_pkg::*;
#(
   parameter int unsigned    ADDR_W   = 6,
   parameter logic [ADDR_W-1:0] DEV_ID = 6'b000101,
   parameter int unsigned    VOL_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       byte_i,
   input  logic             vld_i,
   input  logic             is_data_i,
   output logic             sel_o,
   output logic [1:0]       clk_ratio_o,
   output logic [2:0]       fmt_o,
   output logic [VOL_W-1:0] vol_o,
   output logic [1:0]       deemph_o,
   output logic             mute_o
);
   grp_e       grp;
   sub_e       sub;
   logic       wr_data;

   assign sub     = sub_e'(byte_i[7:6]);
   assign wr_data = vld_i && is_data_i && sel_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o       <= 1'b0;
         grp         <= GRP_PLAY;
         clk_ratio_o <= RATIO_256;
         fmt_o       <= FMT_I2S;
         vol_o       <= '0;
         deemph_o    <= 2'b00;
         mute_o      <= 1'b0;
      end else begin
         if (vld_i && !is_data_i) begin
            sel_o <= (byte_i[7:8-ADDR_W] == DEV_ID);
            grp   <= grp_e'(byte_i[1:0]);
         end
         if (wr_data && grp == GRP_PLAY) begin
            if (sub == SUB_MAIN) begin
               vol_o <= byte_i[VOL_W-1:0];
            end else if (sub == SUB_AUX) begin
               deemph_o <= byte_i[4:3];
               mute_o   <= byte_i[2];
            end
         end
         if (wr_data && grp == GRP_CONF && sub == SUB_MAIN) begin
            if (byte_i[5:4] != RATIO_BAD)   clk_ratio_o <= byte_i[5:4];
            if (byte_i[3:1] <= FMT_LAST_OK) fmt_o       <= byte_i[3:1];
         end
      end
   end
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned ADDR_W      = 6,
   parameter logic [5:0]  DEV_ID      = 6'b000101,
   parameter int unsigned VOL_W       = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_mode_i,
   input  logic       ctl_clk_i,
   input  logic       ctl_dat_i,
   output logic [1:0] clk_ratio_o,
   output logic [2:0] fmt_o,
   output logic [5:0] vol_o,
   output logic [1:0] deemph_o,
   output logic       mute_o
);
   localparam int unsigned N_LINES = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("ctl3w_regfile: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != ctl3w_pkg::CTL_BYTE_W || ADDR_W != 6 || VOL_W != 6) begin : g_bad_fmt
      initial $error("ctl3w_regfile: byte layout requires 8/6/6");
   end

   logic [N_LINES-1:0] lines_s;
   logic [BYTE_W-1:0]  byte_w;
   logic               byte_vld;
   logic               byte_is_data;
   logic               sel;

   ctl3w_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ctl_mode_i, ctl_clk_i, ctl_dat_i}),
      .q_o   (lines_s)
   );

   ctl3w_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_s    (lines_s[2]),
      .sclk_s    (lines_s[1]),
      .sdat_s    (lines_s[0]),
      .byte_o    (byte_w),
      .vld_o     (byte_vld),
      .is_data_o (byte_is_data)
   );

   ctl3w_decode #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .VOL_W(VOL_W)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_i      (byte_w),
      .vld_i       (byte_vld),
      .is_data_i   (byte_is_data),
      .sel_o       (sel),
      .clk_ratio_o (clk_ratio_o),
      .fmt_o       (fmt_o),
      .vol_o       (vol_o),
      .deemph_o    (deemph_o),
      .mute_o      (mute_o)
   );
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_vld,
   input logic       byte_is_data,
   input logic       sel,
   input logic [1:0] clk_ratio_o,
   input logic [2:0] fmt_o,
   input logic [5:0] vol_o,
   input logic [1:0] deemph_o,
   input logic       mute_o
);
   logic [13:0] outs;
   assign outs = {clk_ratio_o, fmt_o, vol_o, deemph_o, mute_o};

   p_commit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(outs));

   p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_is_data && !sel) |=> $stable(outs));

   p_addr_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_is_data) |=> $stable(outs));

   p_ratio_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ratio_o != 2'b11);

   p_fmt_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_o <= 3'b100);
endmodule

bind ctl3w_regfile ctl3w_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .byte_vld     (byte_vld),
   .byte_is_data (byte_is_data),
   .sel          (sel),
   .clk_ratio_o  (clk_ratio_o),
   .fmt_o        (fmt_o),
   .vol_o        (vol_o),
   .deemph_o     (deemph_o),
   .mute_o       (mute_o)
);

// File: tb/test_ctl3w_regfile.sv
module test_ctl3w_regfile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_mode = 1'b0, ctl_clk = 1'b0, ctl_dat = 1'b0;
   logic [1:0] clk_ratio_o;
   logic [2:0] fmt_o;
   logic [5:0] vol_o;
   logic [1:0] deemph_o;
   logic       mute_o;

   int errors = 0, checks = 0;
   bit done = 0;

   logic       m_sel = 0;
   logic [1:0] m_grp = 0, m_ratio = 2'b10, m_deem = 0;
   logic [2:0] m_fmt = 0;
   logic [5:0] m_vol = 0;
   logic       m_mute = 0;

   always #4 clk = ~clk;

   ctl3w_regfile i_ctl3w_regfile (
      .clk(clk), .rst_n(rst_n),
      .ctl_mode_i(ctl_mode), .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat),
      .clk_ratio_o(clk_ratio_o), .fmt_o(fmt_o), .vol_o(vol_o),
      .deemph_o(deemph_o), .mute_o(mute_o)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmp(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      cmp(req, "clk_ratio", clk_ratio_o, m_ratio);
      cmp(req, "fmt",       fmt_o,       m_fmt);
      cmp(req, "vol",       vol_o,       m_vol);
      cmp(req, "deemph",    deemph_o,    m_deem);
      cmp(req, "mute",      mute_o,      m_mute);
   endtask

   // reference model written from the requirements
   task automatic model(input logic is_data, input logic [7:0] b);
      if (!is_data) begin
         m_sel = (b[7:2] == 6'b000101);
         m_grp = b[1:0];
      end else if (m_sel) begin
         if (m_grp == 2'b00 && b[7:6] == 2'b00) m_vol = b[5:0];
         if (m_grp == 2'b00 && b[7:6] == 2'b10) begin
            m_deem = b[4:3];
            m_mute = b[2];
         end
         if (m_grp == 2'b10 && b[7:6] == 2'b00) begin
            if (b[5:4] != 2'b11)  m_ratio = b[5:4];
            if (b[3:1] <= 3'b100) m_fmt   = b[3:1];
         end
      end
   endtask

   task automatic send_bit(input logic b);
      ctl_dat = b;
      wait_cyc(4);
      ctl_clk = 1'b1;
      wait_cyc(4);
      ctl_clk = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      if (ctl_mode != m) begin
         ctl_mode = m;
         wait_cyc(8);
      end
   endtask

   task automatic send_byte(input logic is_data, input logic [7:0] b);
      set_mode(is_data);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
      wait_cyc(10);
      model(is_data, b);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      check_all("R1");

      // R1: data bytes before any address change nothing
      send_byte(1, 8'h2A);
      check_all("R1");

      // R5: every attenuation code, R9 persistence over many bytes
      send_byte(0, 8'h14);
      for (int v = 0; v < 64; v++) begin
         send_byte(1, {2'b00, 6'(v)});
         check_all("R5");
      end
      check_all("R9");

      // R6: de-emphasis and mute, plus ignored sub-selectors
      for (int d = 0; d < 8; d++) begin
         send_byte(1, {2'b10, 1'b0, 2'(d >> 1), 1'(d), 2'b00});
         check_all("R6");
      end
      send_byte(1, 8'h7F);
      check_all("R6");
      send_byte(1, 8'hFF);
      check_all("R6");

      // R7/R8: all ratio and format pairs in the configuration group
      send_byte(0, 8'h16);
      for (int c = 0; c < 32; c++) begin
         send_byte(1, {2'b00, 2'(c >> 3), 3'(c), 1'b0});
         check_all((c >> 3) == 3 || (c & 7) > 4 ? "R8" : "R7");
      end
      send_byte(1, 8'h40);
      check_all("R7");
      send_byte(1, 8'hC2);
      check_all("R7");

      // R2/R3: every address byte followed by a data byte
      for (int a = 0; a < 256; a++) begin
         send_byte(0, 8'(a));
         send_byte(1, {2'b00, 6'(a * 7 + 3)});
         check_all((a >> 2) == 5 ? "R3" : "R2");
      end

      // R4: seven bits must not commit; R10: mode toggle drops them
      send_byte(0, 8'h14);
      set_mode(1);
      for (int i = 0; i < 7; i++) send_bit(i[0]);
      wait_cyc(10);
      check_all("R4");
      set_mode(0);
      set_mode(1);
      send_byte(1, 8'h2D);
      check_all("R10");
      cmp("R10", "vol_direct", vol_o, 45);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule